// File: doc/BRIEF.md
# Paged Effective Address Generator

This block produces the final memory address for memory-reference instructions of a small 8-bit processor whose 15-bit address space is split into four 8 KB pages. An instruction presents its address field, a flag that says whether it is a data operation or an absolute branch, and the current value of the register it names. The top bit of the field asks for one level of indirection: the block then reads a pointer from two consecutive bytes of memory before it produces the address. For data operations the next two bits select an indexing mode, and only the low 13 bits give an offset. That offset is joined to a page register, which only an absolute branch can change.

When the address is ready the block raises a one-cycle valid strobe. With the same strobe it reports whether the named register must be written back with a stepped index value, and whether the data source or destination has moved to register 0. The instruction sequencer, the register file and the memory sit outside the block.

Top module: `paged_ea_gen`

## Requirements
- R1: The field bit FLD_W-1 marks the reference as indirect. For a data operation, field bits ADDR_W-1..ADDR_W-2 give the indexing mode and the low OFS_W bits give the offset. The mode codes are 00 no index, 01 index stepped up by one, 10 index stepped down by one, and 11 index used unchanged.
- R2: A direct data operation yields ea = {page, (offset + index used) mod 2^OFS_W}. The index is zero-extended, and a carry never reaches the page bits.
- R3: In modes 01 and 10 the named register's value is stepped by +1 or -1 (mod 2^IDX_W) before it is used, and the stepped value is the one added to the offset. Mode 11 adds the value unchanged, and mode 00 adds nothing.
- R4: idx_wr is high together with ea_valid exactly for data operations in modes 01 and 10, and idx_wdata then carries the stepped value.
- R5: dst_r0 is high together with ea_valid exactly for data operations in modes 01, 10 and 11. It is never high for a branch.
- R6: After reset the page output is 0. It changes only on the cycle in which an absolute branch completes, and it then takes the top PAGE_W bits of that branch's ea.
- R7: An indirect reference reads two bytes: the first at the pointer location and the second at that location plus one (mod 2^ADDR_W). The pointer is {first byte's low ADDR_W-DATA_W bits, second byte}. The remaining bits of the first byte are ignored, so there is only one level of indirection.
- R8: An indirect data operation reads its pointer at {page, offset} with no index added (post-indexing). Its ea is {pointer page bits, (pointer offset + index used) mod 2^OFS_W}. It leaves the page register unchanged.
- R9: An absolute branch uses all ADDR_W field bits as its address, with no indexing. A direct branch yields the field itself, and an indirect branch yields the pointer read from the location the field names.
- R10: ea_valid rises one cycle after a direct request is accepted and three cycles after an indirect one. busy is high in between, and ptr_rd is never high while ea_valid is high.
- R11: A start that arrives while busy is high is ignored and does not change the result, the page or the write-back of the reference in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request; accepted when busy is low |
| is_branch | input | 1 | 1 = absolute branch, 0 = data operation |
| field | input | FLD_W | Address field with its indirect flag on top |
| idx_in | input | IDX_W | Current value of the named register |
| busy | output | 1 | Pointer read in progress |
| ptr_rd | output | 1 | Pointer byte read request |
| ptr_addr | output | ADDR_W | Pointer byte address |
| ptr_data | input | DATA_W | Byte at ptr_addr, valid in the same cycle |
| ea | output | ADDR_W | Effective address |
| ea_valid | output | 1 | One-cycle strobe: ea and side outputs valid |
| idx_wr | output | 1 | Write idx_wdata back to the named register |
| idx_wdata | output | IDX_W | Stepped index value |
| dst_r0 | output | 1 | Data register replaced by register 0 |
| page | output | PAGE_W | Current page register |

## Verification
The bench builds the block with PAGE_W=2, OFS_W=5, IDX_W=4 and DATA_W=4, which gives a 7-bit address, an 8-bit field and a 128-entry byte memory. At that size it can sweep every field value against every index value for both instruction classes. This covers every mode, every wrap of offset plus index, every page, and every pointer whose discarded top bit is set. Each indirect request is also hit with a stray branch request in its busy window, so the ignore rule is checked on thousands of cases.

// File: rtl/paged_ea_pkg.sv
package paged_ea_pkg;

   typedef enum logic [1:0] {
      IXM_NONE = 2'b00,
      IXM_INC  = 2'b01,
      IXM_DEC  = 2'b10,
      IXM_HOLD = 2'b11
   } ixm_e;

   typedef enum logic [1:0] {
      PS_IDLE   = 2'b00,
      PS_FIRST  = 2'b01,
      PS_SECOND = 2'b10
   } pstate_e;

endpackage

// File: rtl/pea_index_unit.sv
module pea_index_unit
   import paged_ea_pkg::*;
#(
   parameter int IDX_W = 8
) (
   input  logic             is_branch,
   input  ixm_e             mode,
   input  logic [IDX_W-1:0] idx_in,
   output logic [IDX_W-1:0] idx_eff,
   output logic             wr_en,
   output logic             to_r0
);

   always_comb begin
      idx_eff = '0;
      wr_en   = 1'b0;
      to_r0   = 1'b0;
      if (!is_branch) begin
         case (mode)
            IXM_INC: begin
               idx_eff = idx_in + IDX_W'(1);
               wr_en   = 1'b1;
               to_r0   = 1'b1;
            end
            IXM_DEC: begin
               idx_eff = idx_in - IDX_W'(1);
               wr_en   = 1'b1;
               to_r0   = 1'b1;
            end
            IXM_HOLD: begin
               idx_eff = idx_in;
               to_r0   = 1'b1;
            end
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/pea_offset_add.sv
module pea_offset_add #(
   parameter int PAGE_W = 2,
   parameter int OFS_W  = 13,
   parameter int IDX_W  = 8
) (
   input  logic [PAGE_W+OFS_W-1:0] base,
   input  logic [IDX_W-1:0]        idx,
   output logic [PAGE_W+OFS_W-1:0] sum
);

   localparam int ADDR_W = PAGE_W + OFS_W;

   logic [OFS_W-1:0] ofs_sum;

   assign ofs_sum = base[OFS_W-1:0] + OFS_W'(idx);
   assign sum     = {base[ADDR_W-1:OFS_W], ofs_sum};

endmodule

// File: rtl/pea_ptr_seq.sv
module pea_ptr_seq
   import paged_ea_pkg::*;
#(
   parameter int ADDR_W     = 15,
   parameter int DATA_W     = 8,
   parameter bit BIG_ENDIAN = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              go,
   input  logic [ADDR_W-1:0] loc,
   output logic              busy,
   output logic              ptr_rd,
   output logic [ADDR_W-1:0] ptr_addr,
   input  logic [DATA_W-1:0] ptr_data,
   output logic              done,
   output logic [ADDR_W-1:0] ptr_word
);

   localparam int HI_W = ADDR_W - DATA_W;

   pstate_e           state;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] first_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         state   <= PS_IDLE;
         addr_q  <= '0;
         first_q <= '0;
      end else begin
         case (state)
            PS_IDLE: begin
               if (go) begin
                  state  <= PS_FIRST;
                  addr_q <= loc;
               end
            end
            PS_FIRST: begin
               first_q <= ptr_data;
               addr_q  <= addr_q + ADDR_W'(1);
               state   <= PS_SECOND;
            end
            default: state <= PS_IDLE;
         endcase
      end
   end

   assign busy     = (state != PS_IDLE);
   assign ptr_rd   = busy;
   assign ptr_addr = addr_q;
   assign done     = (state == PS_SECOND);

   generate
      if (BIG_ENDIAN) begin : g_big
         logic unused_top;
         assign unused_top = ^first_q[DATA_W-1:HI_W];
         assign ptr_word   = {first_q[HI_W-1:0], ptr_data};
      end else begin : g_little
         logic unused_top;
         assign unused_top = ^ptr_data[DATA_W-1:HI_W];
         assign ptr_word   = {ptr_data[HI_W-1:0], first_q};
      end
   endgenerate

   AST_SECOND_ADDR: assert property (@(posedge clk) disable iff (rst)
      (state == PS_SECOND) |-> (ptr_addr == $past(ptr_addr) + ADDR_W'(1))); // R7

endmodule

// File: rtl/paged_ea_gen.sv
module paged_ea_gen
   import paged_ea_pkg::*;
#(
   parameter int PAGE_W     = 2,
   parameter int OFS_W      = 13,
   parameter int IDX_W      = 8,
   parameter int DATA_W     = 8,
   parameter bit BIG_ENDIAN = 1'b1,
   parameter int RESET_PAGE = 0
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic                       start,
   input  logic                       is_branch,
   input  logic [PAGE_W+OFS_W:0]      field,
   input  logic [IDX_W-1:0]           idx_in,
   output logic                       busy,
   output logic                       ptr_rd,
   output logic [PAGE_W+OFS_W-1:0]    ptr_addr,
   input  logic [DATA_W-1:0]          ptr_data,
   output logic [PAGE_W+OFS_W-1:0]    ea,
   output logic                       ea_valid,
   output logic                       idx_wr,
   output logic [IDX_W-1:0]           idx_wdata,
   output logic                       dst_r0,
   output logic [PAGE_W-1:0]          page
);

   localparam int ADDR_W = PAGE_W + OFS_W;
   localparam int FLD_W  = ADDR_W + 1;

   generate
      if (PAGE_W != 2) begin : g_bad_page
         initial $fatal(1, "PAGE_W must be 2: the mode bits share the page bit positions");
      end
      if (IDX_W > OFS_W) begin : g_bad_idx
         initial $fatal(1, "IDX_W must not exceed OFS_W");
      end
      if (ADDR_W <= DATA_W || ADDR_W >= 2 * DATA_W) begin : g_bad_ptr
         initial $fatal(1, "pointer must span two bytes with spare top bits");
      end
   endgenerate

   // field decode
   logic              f_ind;
   ixm_e              f_mode;
   logic [OFS_W-1:0]  f_ofs;
   logic [ADDR_W-1:0] f_abs;

   assign f_ind  = field[FLD_W-1];
   assign f_mode = ixm_e'(field[ADDR_W-1 -: 2]);
   assign f_ofs  = field[OFS_W-1:0];
   assign f_abs  = field[ADDR_W-1:0];

   logic              accept;
   logic [PAGE_W-1:0] page_q;

   assign accept = start && !busy;

   // index handling on live request
   logic [IDX_W-1:0] eidx_now;
   logic             wr_now;
   logic             r0_now;

   pea_index_unit #(.IDX_W(IDX_W)) u_idx (
      .is_branch (is_branch),
      .mode      (f_mode),
      .idx_in    (idx_in),
      .idx_eff   (eidx_now),
      .wr_en     (wr_now),
      .to_r0     (r0_now)
   );

   // request state held across a pointer read
   logic             br_q;
   logic [IDX_W-1:0] eidx_q;
   logic [IDX_W-1:0] idx_q;
   logic             wr_q;
   logic             r0_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         br_q   <= 1'b0;
         eidx_q <= '0;
         idx_q  <= '0;
         wr_q   <= 1'b0;
         r0_q   <= 1'b0;
      end else if (accept) begin
         br_q   <= is_branch;
         eidx_q <= eidx_now;
         idx_q  <= idx_in;
         wr_q   <= wr_now;
         r0_q   <= r0_now;
      end
   end

   // pointer fetch
   logic              seq_go;
   logic [ADDR_W-1:0] seq_loc;
   logic              seq_done;
   logic [ADDR_W-1:0] ptr_word;

   assign seq_go  = accept && f_ind;
   assign seq_loc = is_branch ? f_abs : {page_q, f_ofs};

   pea_ptr_seq #(
      .ADDR_W     (ADDR_W),
      .DATA_W     (DATA_W),
      .BIG_ENDIAN (BIG_ENDIAN)
   ) u_seq (
      .clk      (clk),
      .rst      (rst),
      .go       (seq_go),
      .loc      (seq_loc),
      .busy     (busy),
      .ptr_rd   (ptr_rd),
      .ptr_addr (ptr_addr),
      .ptr_data (ptr_data),
      .done     (seq_done),
      .ptr_word (ptr_word)
   );

   // shared in-page adder
   logic [ADDR_W-1:0] add_base;
   logic [IDX_W-1:0]  add_idx;
   logic [ADDR_W-1:0] add_sum;

   assign add_base = seq_done ? ptr_word : {page_q, f_ofs};
   assign add_idx  = seq_done ? eidx_q   : eidx_now;

   pea_offset_add #(
      .PAGE_W (PAGE_W),
      .OFS_W  (OFS_W),
      .IDX_W  (IDX_W)
   ) u_add (
      .base (add_base),
      .idx  (add_idx),
      .sum  (add_sum)
   );

   logic              fin_direct;
   logic [ADDR_W-1:0] fin_ea;

   assign fin_direct = accept && !f_ind;
   assign fin_ea     = seq_done ? (br_q ? ptr_word : add_sum)
                                : (is_branch ? f_abs : add_sum);

   // result registers and page register
   logic              ea_valid_q;
   logic [ADDR_W-1:0] ea_q;
   logic              idx_wr_q;
   logic [IDX_W-1:0]  idx_wdata_q;
   logic              dst_r0_q;
   logic              done_br_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         ea_valid_q  <= 1'b0;
         ea_q        <= '0;
         idx_wr_q    <= 1'b0;
         idx_wdata_q <= '0;
         dst_r0_q    <= 1'b0;
         done_br_q   <= 1'b0;
         page_q      <= PAGE_W'(RESET_PAGE);
      end else if (fin_direct) begin
         ea_valid_q  <= 1'b1;
         ea_q        <= fin_ea;
         idx_wr_q    <= wr_now;
         idx_wdata_q <= eidx_now;
         dst_r0_q    <= r0_now;
         done_br_q   <= is_branch;
         if (is_branch) page_q <= fin_ea[ADDR_W-1 -: PAGE_W];
      end else if (seq_done) begin
         ea_valid_q  <= 1'b1;
         ea_q        <= fin_ea;
         idx_wr_q    <= wr_q;
         idx_wdata_q <= eidx_q;
         dst_r0_q    <= r0_q;
         done_br_q   <= br_q;
         if (br_q) page_q <= fin_ea[ADDR_W-1 -: PAGE_W];
      end else begin
         ea_valid_q <= 1'b0;
         idx_wr_q   <= 1'b0;
         dst_r0_q   <= 1'b0;
         done_br_q  <= 1'b0;
      end
   end

   assign ea        = ea_q;
   assign ea_valid  = ea_valid_q;
   assign idx_wr    = idx_wr_q;
   assign idx_wdata = idx_wdata_q;
   assign dst_r0    = dst_r0_q;
   assign page      = page_q;

   AST_PAGE_ONLY_BRANCH: assert property (@(posedge clk) disable iff (rst)
      !$stable(page_q) |-> (ea_valid_q && done_br_q)); // R6
   AST_PAGE_FROM_EA: assert property (@(posedge clk) disable iff (rst)
      (ea_valid_q && done_br_q) |-> (page_q == ea_q[ADDR_W-1 -: PAGE_W])); // R6
   AST_WR_IMPLIES_R0: assert property (@(posedge clk) disable iff (rst)
      idx_wr_q |-> dst_r0_q); // R4
   AST_R0_ONLY_DATA: assert property (@(posedge clk) disable iff (rst)
      dst_r0_q |-> (ea_valid_q && !done_br_q)); // R5
   AST_IDX_STEP: assert property (@(posedge clk) disable iff (rst)
      idx_wr_q |-> ((idx_wdata_q == idx_q + IDX_W'(1)) ||
                    (idx_wdata_q == idx_q - IDX_W'(1)))); // R3
   AST_RD_NOT_VALID: assert property (@(posedge clk) disable iff (rst)
      ptr_rd |-> !ea_valid_q); // R10

endmodule

// File: tb/sim_paged_ea_gen.sv
`timescale 1ns/1ps
module sim_paged_ea_gen;

   localparam int PW = 2;
   localparam int OW = 5;
   localparam int IW = 4;
   localparam int DW = 4;
   localparam int AW = PW + OW;
   localparam int FW = AW + 1;

   logic          clk = 1'b0;
   logic          rst;
   logic          start;
   logic          is_branch;
   logic [FW-1:0] field;
   logic [IW-1:0] idx_in;
   logic          busy;
   logic          ptr_rd;
   logic [AW-1:0] ptr_addr;
   logic [DW-1:0] ptr_data;
   logic [AW-1:0] ea;
   logic          ea_valid;
   logic          idx_wr;
   logic [IW-1:0] idx_wdata;
   logic          dst_r0;
   logic [PW-1:0] page;

   logic [DW-1:0] mem [0:(1<<AW)-1];

   always #2.5 clk = ~clk;

   assign ptr_data = mem[ptr_addr];

   paged_ea_gen #(
      .PAGE_W (PW), .OFS_W (OW), .IDX_W (IW), .DATA_W (DW),
      .BIG_ENDIAN (1'b1), .RESET_PAGE (0)
   ) u0 (
      .clk (clk), .rst (rst), .start (start), .is_branch (is_branch),
      .field (field), .idx_in (idx_in), .busy (busy), .ptr_rd (ptr_rd),
      .ptr_addr (ptr_addr), .ptr_data (ptr_data), .ea (ea),
      .ea_valid (ea_valid), .idx_wr (idx_wr), .idx_wdata (idx_wdata),
      .dst_r0 (dst_r0), .page (page)
   );

   int n_chk  = 0;
   int n_fail = 0;
   bit finished = 1'b0;
   int pg_model = 0;

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int read_ptr(input int loc);
      int hi, lo;
      hi = int'(mem[loc & ((1<<AW)-1)]);
      lo = int'(mem[(loc + 1) & ((1<<AW)-1)]);
      return ((hi & ((1<<(AW-DW))-1)) << DW) | lo;
   endfunction

   task automatic run_op(input int br, input int f, input int ix);
      int ind, mode, ofs, eidx, exp_ea, p, lat, exp_wr, exp_r0, exp_lat;
      string tag;
      ind  = (f >> (FW-1)) & 1;
      mode = (f >> OW) & 3;
      ofs  = f & ((1<<OW)-1);
      eidx = 0; exp_wr = 0; exp_r0 = 0;
      if (br == 0) begin
         case (mode)
            1: begin eidx = (ix + 1) & ((1<<IW)-1); exp_wr = 1; exp_r0 = 1; end
            2: begin eidx = (ix - 1) & ((1<<IW)-1); exp_wr = 1; exp_r0 = 1; end
            3: begin eidx = ix; exp_r0 = 1; end
            default: ;
         endcase
      end
      if (br != 0) begin
         exp_ea = ind ? read_ptr(f & ((1<<AW)-1)) : (f & ((1<<AW)-1));
         tag = ind ? "R7 R9" : "R9";
      end else if (ind == 0) begin
         exp_ea = (pg_model << OW) | ((ofs + eidx) & ((1<<OW)-1));
         tag = "R1 R2 R3";
      end else begin
         p = read_ptr((pg_model << OW) | ofs);
         exp_ea = (p & (((1<<PW)-1) << OW)) | (((p & ((1<<OW)-1)) + eidx) & ((1<<OW)-1));
         tag = "R7 R8 R3";
      end
      if (br != 0) pg_model = exp_ea >> OW;
      exp_lat = ind ? 3 : 1;

      @(negedge clk);
      is_branch = br[0];
      field     = FW'(f);
      idx_in    = IW'(ix);
      start     = 1'b1;
      @(negedge clk);
      start = 1'b0;
      lat = 1;
      while (!ea_valid && lat < 6) begin
         if (lat == 1) begin
            chk("R10 busy", int'(busy), 1);
            // stray request during busy window must be ignored
            start     = 1'b1;
            is_branch = 1'b1;
            field     = FW'((1<<AW) - 1);
            idx_in    = ~IW'(ix);
         end
         @(negedge clk);
         start = 1'b0;
         lat++;
      end
      chk("R10 latency", lat, exp_lat);
      chk({tag, " R11 ea"}, int'(ea), exp_ea);
      chk("R6 R8 R11 page", int'(page), pg_model);
      chk("R4 idx_wr", int'(idx_wr), exp_wr);
      if (exp_wr != 0) chk("R3 R4 idx_wdata", int'(idx_wdata), eidx);
      chk("R5 dst_r0", int'(dst_r0), exp_r0);
   endtask

   initial begin
      rst = 1'b1; start = 1'b0; is_branch = 1'b0; field = '0; idx_in = '0;
      for (int a = 0; a < (1<<AW); a++) mem[a] = DW'(a * 7 + (a >> 3) + 3);
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      chk("R6 reset page", int'(page), 0);
      chk("R10 reset valid", int'(ea_valid), 0);
      chk("R10 reset busy", int'(busy), 0);
      chk("R10 reset ptr_rd", int'(ptr_rd), 0);
      for (int br = 0; br < 2; br++)
         for (int f = 0; f < (1<<FW); f++)
            for (int ix = 0; ix < (1<<IW); ix++)
               run_op(br, f, ix);
      // data sweep again from a non-zero page reached by the branch sweep
      for (int f = 0; f < (1<<FW); f++) run_op(0, f, f & ((1<<IW)-1));
      if (!finished) begin
         finished = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule